// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block sorts every address on a 32-bit system bus into exactly one destination. The 4 GB space is split into four 1 GB quadrants by address bits [31:30]. Quadrant 0 belongs to an external-memory interface with eight chip selects. Quadrant 2 belongs to a DRAM interface with two chip selects. Quadrant 1 holds a 1 MB on-chip ROM at 0x4000_0000. A 1 MB boot window at address zero is sent either to the ROM or to the external-memory interface, depending on a strap pin.

Each chip select has an enable, a base and a size code, all held in a small register file. The register file is loaded through a one-cycle write port. A decode result appears on the registered outputs one clock after the address is presented. The result is a one-hot target vector, a hit flag, and an error flag for addresses that fall into a decoded quadrant but land in no enabled window.

Top module: `cs_addr_map`

## Requirements
- R1: An address with bits [31:20] equal to 0x400 (0x4000_0000 to 0x400F_FFFF) sets target bit 10 (ROM) and the hit flag.
- R2: An external chip-select window i (target bit i, i = 0..7) covers quadrant 0 from its base to base plus its size. The base field is cfg_wdata[29:24], counted in 16 MB units from the start of the quadrant. The size is 16 MB shifted left by the size code in cfg_wdata[1:0], giving 16, 32, 64 or 128 MB. An address inside an enabled window selects bit i.
- R3: The DRAM windows (target bits 8 and 9, register indices 8 and 9) lie in quadrant 2. Their size is 64 MB shifted left by the size code, giving 64 to 512 MB. Window 8 always starts at 0x8000_0000, and the base field written to it is ignored. Window 9 takes a programmable base that resets to 0xA000_0000 (16 MB unit 32).
- R4: An address with bits [31:20] all zero is the boot window. If the latched strap is 1, it selects target bit 10 (ROM). If the latched strap is 0, it selects target bit 11 (boot via external interface). The boot window takes precedence over the chip-select windows.
- R5: The strap input is captured on the first clock edge after reset is released. Later changes of the strap have no effect until the next reset.
- R6: When several enabled windows of one quadrant contain the address, only the lowest-numbered chip select is selected.
- R7: A valid address in quadrant 0 or 2 that misses every enabled window raises the error flag for that one result. No target bit is set and the hit flag is low.
- R8: A valid address in quadrant 1 or 3 outside the ROM range sets neither a target bit, the hit flag nor the error flag.
- R9: A register write is ignored, and the register keeps its previous contents, if the base is not a multiple of the window size or if the register index (cfg_sel) is 10 or above.
- R10: After reset only external chip select 0 is enabled, with base 0 and size 128 MB. All DRAM windows are disabled, so quadrant 2 decodes as errors.
- R11: A register write becomes visible to the decode of the address presented in the cycle after the write. An address presented in the same cycle as the write is decoded with the old settings.
- R12: The outputs are registered one cycle after the address. When addr_valid_i is low, the next result has no target, no hit and no error. The hit flag equals the OR of the target bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_rom_strap_i | input | 1 | Boot strap: 1 sends the boot window to ROM, 0 to the external interface |
| addr_valid_i | input | 1 | Address on addr_i is to be decoded |
| addr_i | input | 32 | Bus address |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 4 | Register index: 0..7 external, 8..9 DRAM |
| cfg_wdata_i | input | 32 | Write data: [31] enable, [29:24] base unit, [1:0] size code |
| sel_o | output | 12 | One-hot target: 0..7 external CS, 8..9 DRAM CS, 10 ROM, 11 boot-external |
| hit_o | output | 1 | A target was selected |
| err_o | output | 1 | Decode error in quadrant 0 or 2 |

## Verification
The clocked properties relate each result to the address of the cycle before it. They therefore take for granted that addr_valid_i stays low while reset is asserted, so that no address straddles the release of reset. The stimulus holds addr_valid_i and cfg_we_i low through every reset and drives addresses only on falling edges after reset is released. The properties also assume that quadrant 0 and quadrant 2 addresses always end in either a chip-select bit of their own quadrant or an error. The sweeps probe every 16 MB unit of both quadrants under several register settings, including overlapping, misaligned and ignored writes.

// File: rtl/cs_map_pkg.sv
package cs_map_pkg;
    localparam int BASE_W   = 6;    // 16 MB units inside a 1 GB quadrant
    localparam int CODE_W   = 2;    // power-of-two size code
    localparam int DRAM_SH  = 2;    // DRAM sizes start at 4 units (64 MB)
    localparam logic [BASE_W-1:0] DRAM1_RST_BASE = 6'h20;
    localparam logic [11:0] ROM_PAGE = 12'h400;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } cs_cfg_t;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import cs_map_pkg::*;
#(
    parameter int N_EXT  = 8,
    parameter int N_DRAM = 2,
    localparam int N_CS  = N_EXT + N_DRAM,
    localparam int IDX_W = $clog2(N_CS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [IDX_W-1:0]     sel_i,
    input  logic [31:0]          wdata_i,
    output cs_cfg_t [N_CS-1:0]   cfg_o
);
    cs_cfg_t [N_CS-1:0] cfg_d, cfg_q;

    function automatic cs_cfg_t reset_value(int idx);
        cs_cfg_t v;
        v.en   = (idx == 0);
        v.code = '1;
        v.base = (idx == N_EXT + 1) ? DRAM1_RST_BASE : '0;
        return v;
    endfunction

    always_comb begin
        logic [BASE_W-1:0] new_base;
        logic [2:0]        shift;
        cfg_d = cfg_q;
        for (int i = 0; i < N_CS; i++) begin
            new_base = (i == N_EXT) ? '0 : wdata_i[29:24];
            shift    = (i < N_EXT) ? {1'b0, wdata_i[1:0]}
                                   : {1'b0, wdata_i[1:0]} + 3'(DRAM_SH);
            if (we_i && (int'(sel_i) == i)
                && ((new_base & ~({BASE_W{1'b1}} << shift)) == '0)) begin
                cfg_d[i].en   = wdata_i[31];
                cfg_d[i].base = new_base;
                cfg_d[i].code = wdata_i[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CS; i++) cfg_q[i] <= reset_value(i);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
    import cs_map_pkg::*;
#(
    parameter int N_EXT  = 8,
    parameter int N_DRAM = 2,
    localparam int N_CS  = N_EXT + N_DRAM
) (
    input  logic [BASE_W-1:0]   unit_i,
    input  logic                in_ext_quad_i,
    input  logic                in_dram_quad_i,
    input  cs_cfg_t [N_CS-1:0]  cfg_i,
    output logic [N_CS-1:0]     match_o
);
    for (genvar i = 0; i < N_CS; i++) begin : g_win
        localparam bit IS_EXT = (i < N_EXT);
        logic [2:0]        shift;
        logic [BASE_W-1:0] mask;
        logic              quad_ok;
        always_comb begin
            shift   = IS_EXT ? {1'b0, cfg_i[i].code}
                             : {1'b0, cfg_i[i].code} + 3'(DRAM_SH);
            mask    = {BASE_W{1'b1}} << shift;
            quad_ok = IS_EXT ? in_ext_quad_i : in_dram_quad_i;
            match_o[i] = cfg_i[i].en && quad_ok
                         && ((unit_i & mask) == cfg_i[i].base);
        end
    end
endmodule

// File: rtl/cs_addr_map.sv
module cs_addr_map
    import cs_map_pkg::*;
#(
    parameter int N_EXT  = 8,
    parameter int N_DRAM = 2,
    localparam int N_CS  = N_EXT + N_DRAM,
    localparam int N_TGT = N_CS + 2,
    localparam int T_ROM = N_CS,
    localparam int T_BOOT = N_CS + 1,
    localparam int IDX_W = $clog2(N_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_rom_strap_i,
    input  logic              addr_valid_i,
    input  logic [31:0]       addr_i,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_sel_i,
    input  logic [31:0]       cfg_wdata_i,
    output logic [N_TGT-1:0]  sel_o,
    output logic              hit_o,
    output logic              err_o
);
    typedef struct packed {
        logic [N_TGT-1:0] sel;
        logic             hit;
        logic             err;
        logic             strap;
        logic             latched;
    } dec_state_t;

    dec_state_t        st_d, st_q;
    cs_cfg_t [N_CS-1:0] cfg;
    logic [N_CS-1:0]   match;
    logic              in_ext_quad, in_dram_quad;

    assign in_ext_quad  = (addr_i[31:30] == 2'd0);
    assign in_dram_quad = (addr_i[31:30] == 2'd2);

    cs_cfg_regs #(.N_EXT(N_EXT), .N_DRAM(N_DRAM)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    cs_window_match #(.N_EXT(N_EXT), .N_DRAM(N_DRAM)) u_match (
        .unit_i         (addr_i[29:24]),
        .in_ext_quad_i  (in_ext_quad),
        .in_dram_quad_i (in_dram_quad),
        .cfg_i          (cfg),
        .match_o        (match)
    );

    always_comb begin
        logic [N_CS-1:0] pick;
        logic            strap_eff;
        logic            boot_win, rom_win;

        boot_win  = (addr_i[31:20] == 12'h000);
        rom_win   = (addr_i[31:20] == ROM_PAGE);
        strap_eff = st_q.latched ? st_q.strap : boot_rom_strap_i;

        pick = '0;
        for (int i = N_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end

        st_d         = st_q;
        st_d.latched = 1'b1;
        if (!st_q.latched) st_d.strap = boot_rom_strap_i;
        st_d.sel = '0;
        st_d.err = 1'b0;

        if (addr_valid_i) begin
            if (boot_win) begin
                if (strap_eff) st_d.sel[T_ROM]  = 1'b1;
                else           st_d.sel[T_BOOT] = 1'b1;
            end else if (rom_win) begin
                st_d.sel[T_ROM] = 1'b1;
            end else if (in_ext_quad || in_dram_quad) begin
                if (match != '0) st_d.sel[N_CS-1:0] = pick;
                else             st_d.err = 1'b1;
            end
        end
        st_d.hit = |st_d.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;
    assign hit_o = st_q.hit;
    assign err_o = st_q.err;
endmodule

// File: rtl/cs_addr_map_chk.sv
module cs_addr_map_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_valid_i,
    input logic [31:0] addr_i,
    input logic [11:0] sel_o,
    input logic        hit_o,
    input logic        err_o
);
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    p_hit_or_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == (sel_o != '0));

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (sel_o == '0) && !hit_o);

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid_i |=> !hit_o && !err_o);

    p_rom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_i && addr_i[31:20] == 12'h400 |=> sel_o[10] && hit_o);

    p_odd_quad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_i && addr_i[30] && addr_i[31:20] != 12'h400
        |=> !hit_o && !err_o);

    p_ext_quad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_i && addr_i[31:30] == 2'd0 && addr_i[29:20] != '0
        |=> err_o || (sel_o[7:0] != '0));

    p_dram_quad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_i && addr_i[31:30] == 2'd2
        |=> err_o || (sel_o[9:8] != '0));
endmodule

bind cs_addr_map cs_addr_map_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid_i (addr_valid_i),
    .addr_i       (addr_i),
    .sel_o        (sel_o),
    .hit_o        (hit_o),
    .err_o        (err_o)
);

// File: tb/cs_addr_map_test.sv
module cs_addr_map_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [11:0] sel;
    logic        hit, err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    // shadow of the programmed windows, kept from the requirements
    bit       m_en   [10];
    int       m_base [10];
    int       m_code [10];
    bit       m_strap;

    always #4 clk = ~clk;

    cs_addr_map uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .boot_rom_strap_i (strap),
        .addr_valid_i     (addr_valid),
        .addr_i           (addr),
        .cfg_we_i         (cfg_we),
        .cfg_sel_i        (cfg_sel),
        .cfg_wdata_i      (cfg_wdata),
        .sel_o            (sel),
        .hit_o            (hit),
        .err_o            (err)
    );

    function automatic int units(int idx, int code);
        return (idx < 8) ? (1 << code) : (4 << code);
    endfunction

    function automatic logic [11:0] model_sel(logic [31:0] a);
        logic [11:0] r = '0;
        int u = int'(a[29:24]);
        int q = int'(a[31:30]);
        if (a < 32'h0010_0000) begin
            r[m_strap ? 10 : 11] = 1'b1;
        end else if (a >= 32'h4000_0000 && a < 32'h4010_0000) begin
            r[10] = 1'b1;
        end else if (q == 0 || q == 2) begin
            for (int i = 9; i >= 0; i--) begin
                bit right_q = (i < 8) ? (q == 0) : (q == 2);
                int sz = units(i, m_code[i]);
                if (m_en[i] && right_q && u >= m_base[i] && u < m_base[i] + sz) begin
                    r = '0;
                    r[i] = 1'b1;
                end
            end
        end
        return r;
    endfunction

    task automatic compare(string req, logic [11:0] es, logic eh, logic ee);
        n_checks++;
        if (sel !== es || hit !== eh || err !== ee) begin
            n_fails++;
            $display("FAIL %s addr=%h: sel=%h hit=%b err=%b expected sel=%h hit=%b err=%b",
                     req, addr, sel, hit, err, es, eh, ee);
        end
    endtask

    task automatic probe(logic [31:0] a, string req);
        logic [11:0] es;
        logic        ee;
        es = model_sel(a);
        ee = (es == '0) && (a[31:30] == 2'd0 || a[31:30] == 2'd2);
        addr_valid = 1'b1;
        addr = a;
        @(negedge clk);
        compare(req, es, es != '0, ee);
        addr_valid = 1'b0;
    endtask

    task automatic do_reset(bit s);
        rst_n = 1'b0;
        addr_valid = 1'b0;
        cfg_we = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_strap = s;
        for (int i = 0; i < 10; i++) begin
            m_en[i] = (i == 0);
            m_base[i] = (i == 9) ? 32 : 0;
            m_code[i] = 3;
        end
    endtask

    task automatic shadow_write(int idx, bit en, int base, int code);
        int b;
        if (idx < 10) begin
            b = (idx == 8) ? 0 : base;
            if (b % units(idx, code) == 0) begin
                m_en[idx] = en;
                m_base[idx] = b;
                m_code[idx] = code;
            end
        end
    endtask

    task automatic cfg_write(int idx, bit en, int base, int code);
        cfg_we = 1'b1;
        cfg_sel = 4'(idx);
        cfg_wdata = {en, 1'b0, 6'(base), 22'd0, 2'(code)};
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(idx, en, base, code);
    endtask

    task automatic sweep_quads(string req);
        for (int u = 0; u < 64; u++) begin
            probe({2'b00, 6'(u), 24'h10_0000}, req);
            probe({2'b10, 6'(u), 24'h12_3456}, req);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        // R10 / R12: reset outputs are quiet
        compare("R10", '0, 1'b0, 1'b0);
        @(negedge clk);
        compare("R12", '0, 1'b0, 1'b0);

        // R10: reset windows, R7: quadrant 2 all errors
        sweep_quads("R10_R7");

        // R1 / R8: quadrants 1 and 3
        probe(32'h4000_0000, "R1");
        probe(32'h400F_FFFF, "R1");
        probe(32'h4010_0000, "R8");
        probe(32'h7FFF_FFFF, "R8");
        probe(32'hC000_0000, "R8");
        probe(32'hFFFF_FFFF, "R8");

        // R4: boot window with ROM strap, R2: just past it goes to CS0
        probe(32'h0000_0000, "R4");
        probe(32'h000F_FFFF, "R4");
        probe(32'h0010_0000, "R2");

        // R5: strap changes after reset are ignored
        strap = 1'b0;
        @(negedge clk);
        probe(32'h0000_1000, "R5");

        // R2 / R6 / R9 / R3: programmed windows
        cfg_write(1, 1'b1, 8, 2);     // units 8..11
        cfg_write(2, 1'b1, 10, 1);    // 10..11, shadowed by cs1 (R6)
        cfg_write(3, 1'b1, 13, 2);    // misaligned, ignored (R9)
        cfg_write(4, 1'b1, 16, 2);    // 16..19
        cfg_write(5, 1'b1, 18, 1);    // shadowed by cs4 (R6)
        cfg_write(7, 1'b1, 63, 0);    // last unit
        cfg_write(8, 1'b1, 5, 1);     // base field ignored (R3)
        cfg_write(9, 1'b1, 32, 2);    // 32..47
        cfg_write(9, 1'b1, 36, 3);    // misaligned, ignored (R9)
        cfg_write(15, 1'b1, 0, 0);    // index out of range, ignored (R9)
        sweep_quads("R2_R3_R6_R9");
        probe(32'h0D00_0000, "R9");   // cs3 write was ignored: error
        probe(32'h0A80_0000, "R6");   // cs1 wins over cs2
        probe(32'h8600_0000, "R3");   // DRAM0 fixed base, 128 MB
        probe(32'hA000_0000, "R3");   // DRAM1 at its reset base

        // R11: same-cycle write uses old settings, next decode new ones
        cfg_we = 1'b1;
        cfg_sel = 4'd0;
        cfg_wdata = {1'b0, 1'b0, 6'd0, 22'd0, 2'd3};
        addr_valid = 1'b1;
        addr = 32'h0200_0000;
        @(negedge clk);
        cfg_we = 1'b0;
        addr_valid = 1'b0;
        compare("R11", 12'h001, 1'b1, 1'b0);
        shadow_write(0, 1'b0, 0, 3);
        probe(32'h0200_0000, "R11");
        sweep_quads("R11_R7");

        // R4 / R5: reset with external boot strap
        do_reset(1'b0);
        probe(32'h0000_0000, "R4");
        strap = 1'b1;
        @(negedge clk);
        probe(32'h0008_0000, "R5");
        probe(32'h4000_0040, "R1");

        // R12: idle cycle after a hit
        probe(32'h0300_0000, "R12");
        @(negedge clk);
        compare("R12", '0, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule